// File: doc/BRIEF.md
# Device-Register Remap Table

This block holds a small associative table that diverts accesses by unprivileged cores to selected device registers. The diverted accesses land on shadow copies in memory owned by the privileged partition. Each table row pairs a device-register physical address with the shadow address that replaces it. A valid bit tells whether the row takes part in lookups.

The block answers two kinds of question:

- **Page query.** A TLB refill issues this query. For an uncacheable page, it tells the refill whether any live row falls inside that 4 KiB page, so the new TLB entry can carry a redirect flag.
- **Exact query.** An access that hits a redirect-flagged TLB entry issues this query. It compares the full address and, on a match, substitutes the shadow address. It also fires a one-cycle notification aimed at a privileged core.

Rows and the notification destination are written through a configuration port. That port takes effect only when the writer is marked privileged. Both query paths return a registered answer exactly one cycle after the request, whatever the outcome.

Top module: `mmio_remap_unit`

## Requirements
- R1: After reset, no row is live, both acknowledge outputs and all result and notification outputs are 0, and the notification destination is core 0.
- R2: An uncacheable page query (fill_uncached=1) sets fill_redirect when a live row's address has the same bits [63:12] as fill_paddr; otherwise fill_redirect is 0.
- R3: A cacheable page query (fill_uncached=0) never sets fill_redirect, even when a live row lies in that page.
- R4: A flagged access (acc_flagged=1) whose full address equals a live row's original address returns that row's shadow address on acc_paddr_out with acc_remapped=1.
- R5: When several live rows hold the same original address, the row with the lowest index supplies the shadow address and the reported index.
- R6: Each remapped access raises notify_valid for exactly the cycle of its result, carrying the matched row index, the requesting core ID, and the programmed destination core.
- R7: An access without the flag returns its own address unchanged, with acc_remapped=0 and no notification, even when the address matches a live row.
- R8: A flagged access that matches no live row returns its own address unchanged, with acc_remapped=0 and no notification.
- R9: A configuration write changes state only when cfg_priv=1. cfg_sel=0 writes row cfg_idx (valid, original, shadow), and cfg_sel=1 writes the destination core. Writes with cfg_priv=0 are ignored.
- R10: A row whose valid bit is 0 matches neither query.
- R11: Both query kinds acknowledge exactly one cycle after the request, with the same latency for flagged, unflagged, hit and miss cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Writer is a privileged core |
| cfg_sel | input | 1 | 0: row write, 1: destination core write |
| cfg_idx | input | 4 | Row index for a row write |
| cfg_valid | input | 1 | Valid bit written to the row |
| cfg_orig | input | 64 | Original device-register address |
| cfg_target | input | 64 | Shadow address |
| cfg_dest | input | 6 | Notification destination core ID |
| fill_req | input | 1 | Page query request |
| fill_uncached | input | 1 | Walk result is uncacheable |
| fill_paddr | input | 64 | Physical address from the walk |
| fill_ack | output | 1 | Page query answer valid |
| fill_redirect | output | 1 | Set redirect flag in new TLB entry |
| acc_req | input | 1 | Access query request |
| acc_flagged | input | 1 | Hit TLB entry has redirect flag |
| acc_paddr | input | 64 | Translated access address |
| acc_core | input | 6 | Requesting core ID |
| acc_ack | output | 1 | Access answer valid |
| acc_remapped | output | 1 | Shadow address substituted |
| acc_paddr_out | output | 64 | Final access address |
| notify_valid | output | 1 | Notification pulse |
| notify_idx | output | 4 | Matched row index |
| notify_src_core | output | 6 | Core that made the access |
| notify_dst_core | output | 6 | Privileged core to notify |

## Verification
A corrupted row or valid bit shows up in the very next answer that uses it. A page query reports the wrong redirect decision, and a flagged access returns the wrong address or a notification with the wrong index, one cycle after the request. A bad priority choice among duplicate rows is visible only when duplicates are live, so the stimulus keeps two rows with the same address and later retires the lower one. A lost or spurious configuration write stays hidden until a query touches the affected row or the destination field. For that reason, every ignored write is followed by a query that would expose it.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic {
    CFG_ROW  = 1'b0,
    CFG_DEST = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/remap_table.sv
module remap_table
  import remap_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 64,
  parameter int CW = 6,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_priv,
  input  logic          cfg_sel,
  input  logic [IW-1:0] cfg_idx,
  input  logic          cfg_valid,
  input  logic [AW-1:0] cfg_orig,
  input  logic [AW-1:0] cfg_target,
  input  logic [CW-1:0] cfg_dest,
  output logic [N-1:0]  ent_valid,
  output logic [AW-1:0] ent_orig   [N],
  output logic [AW-1:0] ent_target [N],
  output logic [CW-1:0] dest_core
);
  logic wr_row, wr_dest;

  assign wr_row  = cfg_we && cfg_priv && (cfg_sel == CFG_ROW) && (32'(cfg_idx) < N);
  assign wr_dest = cfg_we && cfg_priv && (cfg_sel == CFG_DEST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
      dest_core <= '0;
    end else begin
      if (wr_row)  ent_valid[cfg_idx] <= cfg_valid;
      if (wr_dest) dest_core <= cfg_dest;
    end
  end

  // Address storage carries no reset; the valid bits gate every use.
  always_ff @(posedge clk) begin
    if (wr_row) begin
      ent_orig[cfg_idx]   <= cfg_orig;
      ent_target[cfg_idx] <= cfg_target;
    end
  end

  p_unpriv_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_priv) |=> ($stable(ent_valid) && $stable(dest_core)));
endmodule

// File: rtl/remap_match.sv
module remap_match #(
  parameter int N  = 16,
  parameter int AW = 64,
  parameter int PS = 12,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  ent_valid,
  input  logic [AW-1:0] ent_orig [N],
  input  logic [AW-1:0] page_addr,
  input  logic [AW-1:0] exact_addr,
  output logic          page_hit,
  output logic          exact_hit,
  output logic [IW-1:0] exact_idx
);
  logic [N-1:0] page_eq, exact_eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign page_eq[g]  = ent_valid[g] && (ent_orig[g][AW-1:PS] == page_addr[AW-1:PS]);
    assign exact_eq[g] = ent_valid[g] && (ent_orig[g] == exact_addr);
  end

  assign page_hit  = |page_eq;
  assign exact_hit = |exact_eq;

  // Downward scan so the lowest matching index is the last one assigned.
  always_comb begin
    exact_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (exact_eq[i]) exact_idx = IW'(i);
    end
  end
endmodule

// File: rtl/mmio_remap_unit.sv
module mmio_remap_unit
  import remap_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 64,
  parameter int CW = 6,
  parameter int PS = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_priv,
  input  logic          cfg_sel,
  input  logic [IW-1:0] cfg_idx,
  input  logic          cfg_valid,
  input  logic [AW-1:0] cfg_orig,
  input  logic [AW-1:0] cfg_target,
  input  logic [CW-1:0] cfg_dest,
  input  logic          fill_req,
  input  logic          fill_uncached,
  input  logic [AW-1:0] fill_paddr,
  output logic          fill_ack,
  output logic          fill_redirect,
  input  logic          acc_req,
  input  logic          acc_flagged,
  input  logic [AW-1:0] acc_paddr,
  input  logic [CW-1:0] acc_core,
  output logic          acc_ack,
  output logic          acc_remapped,
  output logic [AW-1:0] acc_paddr_out,
  output logic          notify_valid,
  output logic [IW-1:0] notify_idx,
  output logic [CW-1:0] notify_src_core,
  output logic [CW-1:0] notify_dst_core
);
  logic [N-1:0]  ent_valid;
  logic [AW-1:0] ent_orig   [N];
  logic [AW-1:0] ent_target [N];
  logic [CW-1:0] dest_core;
  logic          page_hit, exact_hit;
  logic [IW-1:0] exact_idx;
  logic          do_remap;

  remap_table #(.N(N), .AW(AW), .CW(CW), .IW(IW)) u_table (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_orig(cfg_orig), .cfg_target(cfg_target),
    .cfg_dest(cfg_dest),
    .ent_valid(ent_valid), .ent_orig(ent_orig), .ent_target(ent_target),
    .dest_core(dest_core)
  );

  remap_match #(.N(N), .AW(AW), .PS(PS), .IW(IW)) u_match (
    .ent_valid(ent_valid), .ent_orig(ent_orig),
    .page_addr(fill_paddr), .exact_addr(acc_paddr),
    .page_hit(page_hit), .exact_hit(exact_hit), .exact_idx(exact_idx)
  );

  assign do_remap = acc_req && acc_flagged && exact_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_ack        <= 1'b0;
      fill_redirect   <= 1'b0;
      acc_ack         <= 1'b0;
      acc_remapped    <= 1'b0;
      acc_paddr_out   <= '0;
      notify_valid    <= 1'b0;
      notify_idx      <= '0;
      notify_src_core <= '0;
      notify_dst_core <= '0;
    end else begin
      fill_ack      <= fill_req;
      fill_redirect <= fill_req && fill_uncached && page_hit;
      acc_ack       <= acc_req;
      acc_remapped  <= do_remap;
      acc_paddr_out <= do_remap ? ent_target[exact_idx] : acc_paddr;
      notify_valid  <= do_remap;
      if (do_remap) begin
        notify_idx      <= exact_idx;
        notify_src_core <= acc_core;
        notify_dst_core <= dest_core;
      end
    end
  end

  p_cached_skip_r3: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !fill_uncached) |=> !fill_redirect);

  p_unflagged_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_flagged) |=>
      (acc_ack && !acc_remapped && !notify_valid && acc_paddr_out == $past(acc_paddr)));

  p_notify_src_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_flagged && exact_hit) |=>
      (notify_valid && notify_src_core == $past(acc_core)));

  p_acc_latency_r11: assert property (@(posedge clk) disable iff (rst)
    acc_req |=> acc_ack);

  p_fill_latency_r11: assert property (@(posedge clk) disable iff (rst)
    fill_req |=> fill_ack);
endmodule

// File: tb/sim_mmio_remap_unit.sv
module sim_mmio_remap_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_priv, cfg_sel, cfg_valid;
  logic [3:0]  cfg_idx;
  logic [63:0] cfg_orig, cfg_target;
  logic [5:0]  cfg_dest;
  logic        fill_req, fill_uncached;
  logic [63:0] fill_paddr;
  logic        fill_ack, fill_redirect;
  logic        acc_req, acc_flagged;
  logic [63:0] acc_paddr;
  logic [5:0]  acc_core;
  logic        acc_ack, acc_remapped;
  logic [63:0] acc_paddr_out;
  logic        notify_valid;
  logic [3:0]  notify_idx;
  logic [5:0]  notify_src_core, notify_dst_core;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mmio_remap_unit u0 (.*);

  typedef struct packed {
    logic        is_acc;
    logic        flag;      // uncached for fills, redirect flag for accesses
    logic [63:0] addr;
    logic [5:0]  core;
    logic        exp_hit;
    logic [63:0] exp_addr;
    logic [3:0]  exp_idx;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 64'hFEB0_0ABC, 6'd0, 1'b1, 64'h0,          4'd0}, // R2 page hit
    '{1'b0, 1'b0, 64'hFEB0_0ABC, 6'd0, 1'b0, 64'h0,          4'd0}, // R3 cacheable
    '{1'b0, 1'b1, 64'hFEB0_2000, 6'd0, 1'b0, 64'h0,          4'd0}, // R2 empty page
    '{1'b0, 1'b1, 64'hFEB0_5123, 6'd0, 1'b0, 64'h0,          4'd0}, // R10 invalid row
    '{1'b0, 1'b1, 64'hFEB0_7010, 6'd0, 1'b0, 64'h0,          4'd0}, // R9 unpriv row
    '{1'b1, 1'b1, 64'hFEB0_0818, 6'd3, 1'b1, 64'h8000_0010, 4'd0}, // R4 R5
    '{1'b1, 1'b1, 64'hFEB0_3818, 6'd2, 1'b1, 64'h8000_0020, 4'd1}, // R4
    '{1'b1, 1'b1, 64'hFEB0_081C, 6'd1, 1'b0, 64'hFEB0_081C, 4'd0}, // R8
    '{1'b1, 1'b0, 64'hFEB0_0818, 6'd1, 1'b0, 64'hFEB0_0818, 4'd0}, // R7
    '{1'b1, 1'b1, 64'hFEB0_1000, 6'd5, 1'b1, 64'h8000_0040, 4'd4}, // R4
    '{1'b1, 1'b1, 64'hFEB0_5000, 6'd1, 1'b0, 64'hFEB0_5000, 4'd0}, // R10
    '{1'b0, 1'b1, 64'hFEB0_1FFF, 6'd0, 1'b1, 64'h0,          4'd0}  // R2 page edge
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic cfg_write(input logic priv, input logic sel, input logic [3:0] idx,
                           input logic v, input logic [63:0] o, input logic [63:0] t,
                           input logic [5:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = priv; cfg_sel = sel; cfg_idx = idx;
    cfg_valid = v; cfg_orig = o; cfg_target = t; cfg_dest = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input string req);
    @(negedge clk);
    if (v.is_acc) begin
      acc_req = 1'b1; acc_flagged = v.flag; acc_paddr = v.addr; acc_core = v.core;
    end else begin
      fill_req = 1'b1; fill_uncached = v.flag; fill_paddr = v.addr;
    end
    @(negedge clk);
    acc_req = 1'b0; fill_req = 1'b0;
    if (v.is_acc) begin
      chk({req, " R11 acc_ack"}, 64'(acc_ack), 64'd1);
      chk({req, " remapped"}, 64'(acc_remapped), 64'(v.exp_hit));
      chk({req, " paddr_out"}, acc_paddr_out, v.exp_addr);
      chk({req, " R6 notify"}, 64'(notify_valid), 64'(v.exp_hit));
      if (v.exp_hit) begin
        chk({req, " R6 idx"}, 64'(notify_idx), 64'(v.exp_idx));
        chk({req, " R6 src"}, 64'(notify_src_core), 64'(v.core));
        chk({req, " R6 dst"}, 64'(notify_dst_core), 64'd7);
      end
    end else begin
      chk({req, " R11 fill_ack"}, 64'(fill_ack), 64'd1);
      chk({req, " redirect"}, 64'(fill_redirect), 64'(v.exp_hit));
    end
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst = 1'b1;
    cfg_we = 0; cfg_priv = 0; cfg_sel = 0; cfg_idx = 0; cfg_valid = 0;
    cfg_orig = 0; cfg_target = 0; cfg_dest = 0;
    fill_req = 0; fill_uncached = 0; fill_paddr = 0;
    acc_req = 0; acc_flagged = 0; acc_paddr = 0; acc_core = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 fill_ack", 64'(fill_ack), 0);
    chk("R1 acc_ack", 64'(acc_ack), 0);
    chk("R1 notify", 64'(notify_valid), 0);
    chk("R1 paddr_out", acc_paddr_out, 0);
    // R1: nothing live after reset
    run_vec('{1'b0, 1'b1, 64'hFEB0_0818, 6'd0, 1'b0, 64'h0, 4'd0}, "R1 empty");

    // Program rows (R9: privileged), dest core 7, plus ignored unprivileged writes
    cfg_write(1, 0, 4'd0, 1, 64'hFEB0_0818, 64'h8000_0010, 0);
    cfg_write(1, 0, 4'd1, 1, 64'hFEB0_3818, 64'h8000_0020, 0);
    cfg_write(1, 0, 4'd2, 0, 64'hFEB0_5000, 64'h8000_0099, 0);
    cfg_write(1, 0, 4'd3, 1, 64'hFEB0_0818, 64'h8000_0030, 0);
    cfg_write(1, 0, 4'd4, 1, 64'hFEB0_1000, 64'h8000_0040, 0);
    cfg_write(1, 1, 4'd0, 0, 0, 0, 6'd7);
    cfg_write(0, 0, 4'd6, 1, 64'hFEB0_7010, 64'h8000_0060, 0);
    cfg_write(0, 1, 4'd0, 0, 0, 0, 6'd9);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], $sformatf("vec%0d", i));

    // R6: pulse lasts one cycle only
    @(negedge clk);
    acc_req = 1; acc_flagged = 1; acc_paddr = 64'hFEB0_3818; acc_core = 6'd4;
    @(negedge clk);
    acc_req = 0;
    chk("R6 pulse on", 64'(notify_valid), 1);
    @(negedge clk);
    chk("R6 pulse off", 64'(notify_valid), 0);

    // R5: retire row 0, the duplicate in row 3 now wins
    cfg_write(1, 0, 4'd0, 0, 64'hFEB0_0818, 64'h8000_0010, 0);
    run_vec('{1'b1, 1'b1, 64'hFEB0_0818, 6'd3, 1'b1, 64'h8000_0030, 4'd3}, "R5 fallback");

    // R10: retire row 4, its page no longer redirects
    cfg_write(1, 0, 4'd4, 0, 64'hFEB0_1000, 64'h8000_0040, 0);
    run_vec('{1'b0, 1'b1, 64'hFEB0_1000, 6'd0, 1'b0, 64'h0, 4'd0}, "R10 retired");

    // R11: back-to-back accesses each answered one cycle later
    @(negedge clk);
    acc_req = 1; acc_flagged = 0; acc_paddr = 64'h1234;
    @(negedge clk);
    acc_paddr = 64'h5678;
    chk("R11 b2b first", acc_paddr_out, 64'h1234);
    @(negedge clk);
    acc_req = 0;
    chk("R11 b2b second", acc_paddr_out, 64'h5678);
    chk("R11 b2b ack", 64'(acc_ack), 1);
    @(negedge clk);
    chk("R11 idle ack", 64'(acc_ack), 0);

    report();
  end
endmodule